// File: doc/BRIEF.md
# Issue Queue Wakeup Tag Matcher

This block is the tag-match half of an out-of-order scheduler's issue queue. The queue does not hold operand data. Each entry holds two source operand tags, one ready flag per source and a valid bit. In every cycle, each valid entry compares both of its stored tags against every result tag that the execution units broadcast. When any bus carries a tag equal to a stored tag, that source becomes ready and stays ready. When both sources of a valid entry are ready, the entry raises a registered request for an external select stage.

The valid bit also sets the entry's wear-recovery mode. A free entry holds its tag storage at all ones, which is the boost state for those bits. The entry's comparators are disabled while it is free, so the forced-high bits can never produce a false wakeup. The valid bit itself is never forced. Allocation through a dispatch port is the only way out of the boost state. The new tags, and any wakeup from a tag broadcast in that same cycle, are in effect from the next cycle. Select logic and the payload RAM are outside this block.

Top module: `iq_wakeup_cam`

## Requirements
- R1: After a synchronous reset, every `entry_valid_o`, `src_ready_o` and `request_o` bit is 0.
- R2: A dispatch port with its valid bit high writes the entry named by its index. On the next cycle that entry shows valid=1, and its source ready flags equal the dispatched ready bits (bit 0 = source 0, bit 1 = source 1).
- R3: A broadcast bus with its valid bit high whose tag equals a valid entry's stored source tag in all 7 bits sets that source's ready flag on the next cycle. Any of the four buses can cause this. A tag that differs in a single bit does not set the flag.
- R4: A source ready flag stays set on every later cycle until its entry is freed.
- R5: A tag broadcast in the same cycle as a dispatch is compared against the incoming tags. A match sets that source's ready flag in the first cycle the entry is visible.
- R6: A free entry is in boost mode. Its stored tags are held at all ones (127) and its match logic is disabled, so a broadcast of 127 does not make it ready. Once the entry is allocated with a tag of 127, that same broadcast does wake it.
- R7: An issue/free port with its valid bit high clears the named entry's valid bit, both ready flags and its request on the next cycle. Other entries are not affected.
- R8: `request_o` of an entry is a registered copy of (valid AND source 0 ready AND source 1 ready). It rises in the same cycle as the ready flag that completes it.
- R9: When a dispatch and a free name the same entry in the same cycle, the dispatch wins and the entry holds the new instruction.
- R10: A broadcast bus whose valid bit is low causes no wakeup, even when its tag matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_vld_i | input | NUM_DISP | Dispatch valid, one per port |
| disp_idx_i | input | NUM_DISP*IDX_W | Target entry per dispatch port |
| disp_tag_i | input | NUM_DISP*2*TAG_W | Source tags per port, source 0 in the low half |
| disp_rdy_i | input | NUM_DISP*2 | Source already-available bits per port |
| free_vld_i | input | NUM_ISSUE | Issue/free valid, one per port |
| free_idx_i | input | NUM_ISSUE*IDX_W | Entry freed per port |
| bc_vld_i | input | NUM_BCAST | Result broadcast valid per bus |
| bc_tag_i | input | NUM_BCAST*TAG_W | Result tag per bus |
| entry_valid_o | output | NUM_ENTRIES | Valid bit per entry |
| src_ready_o | output | NUM_ENTRIES*2 | Ready flags, entry e source s at bit 2e+s |
| request_o | output | NUM_ENTRIES | Entry ready to issue |

## Verification
The bench builds the block with 8 entries, 7-bit tags and four ports of each kind. Using few entries makes every entry's state easy to check and lets scenarios on separate entries run side by side. Keeping the tag width at its full value means a single-bit near-miss tag and the all-ones boost value are both still meaningful. With four ports of each kind, the bench can drive several dispatches, frees and broadcasts in one cycle, including a dispatch and a free colliding on the same entry.

// File: rtl/iqw_pkg.sv
package iqw_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic {
    MODE_BOOST  = 1'b0,
    MODE_NORMAL = 1'b1
  } cell_mode_e;
endpackage

// File: rtl/iqw_match.sv
module iqw_match #(
  parameter int TAG_W     = 7,
  parameter int NUM_BCAST = 4
) (
  input  logic [TAG_W-1:0]           tag_i,
  input  logic                       eval_en_i,
  input  logic [NUM_BCAST-1:0]       bc_vld_i,
  input  logic [NUM_BCAST*TAG_W-1:0] bc_tag_i,
  output logic                       hit_o
);
  logic [NUM_BCAST-1:0] line;

  for (genvar b = 0; b < NUM_BCAST; b++) begin : g_bus
    assign line[b] = eval_en_i && bc_vld_i[b] &&
                     (tag_i == bc_tag_i[b*TAG_W +: TAG_W]);
  end

  assign hit_o = |line;
endmodule

// File: rtl/iqw_entry.sv
module iqw_entry
  import iqw_pkg::*;
#(
  parameter int TAG_W     = 7,
  parameter int NUM_BCAST = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       disp_hit_i,
  input  logic [NUM_SRC*TAG_W-1:0]   disp_tags_i,
  input  logic [NUM_SRC-1:0]         disp_rdy_i,
  input  logic                       free_hit_i,
  input  logic [NUM_BCAST-1:0]       bc_vld_i,
  input  logic [NUM_BCAST*TAG_W-1:0] bc_tag_i,
  output logic                       valid_o,
  output logic [NUM_SRC-1:0]         rdy_o,
  output logic                       req_o
);
  localparam logic [NUM_SRC*TAG_W-1:0] BOOST_VAL = '1;

  cell_mode_e                 mode_q;
  logic [NUM_SRC*TAG_W-1:0]   tags_q;
  logic [NUM_SRC-1:0]         rdy_q;
  logic                       req_q;
  logic [NUM_SRC-1:0]         st_hit, in_hit;

  cell_mode_e                 mode_d;
  logic [NUM_SRC*TAG_W-1:0]   tags_d;
  logic [NUM_SRC-1:0]         rdy_d;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    iqw_match #(.TAG_W(TAG_W), .NUM_BCAST(NUM_BCAST)) u_st (
      .tag_i     (tags_q[s*TAG_W +: TAG_W]),
      .eval_en_i (mode_q == MODE_NORMAL),
      .bc_vld_i  (bc_vld_i),
      .bc_tag_i  (bc_tag_i),
      .hit_o     (st_hit[s])
    );
    iqw_match #(.TAG_W(TAG_W), .NUM_BCAST(NUM_BCAST)) u_in (
      .tag_i     (disp_tags_i[s*TAG_W +: TAG_W]),
      .eval_en_i (disp_hit_i),
      .bc_vld_i  (bc_vld_i),
      .bc_tag_i  (bc_tag_i),
      .hit_o     (in_hit[s])
    );
  end

  always_comb begin
    mode_d = mode_q;
    tags_d = tags_q;
    rdy_d  = rdy_q | st_hit;
    if (disp_hit_i) begin
      mode_d = MODE_NORMAL;
      tags_d = disp_tags_i;
      rdy_d  = disp_rdy_i | in_hit;
    end else if (free_hit_i) begin
      mode_d = MODE_BOOST;
      tags_d = BOOST_VAL;
      rdy_d  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_BOOST;
      tags_q <= BOOST_VAL;
      rdy_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      tags_q <= tags_d;
      rdy_q  <= rdy_d;
      req_q  <= (mode_d == MODE_NORMAL) && (&rdy_d);
    end
  end

  assign valid_o = (mode_q == MODE_NORMAL);
  assign rdy_o   = rdy_q;
  assign req_o   = req_q;

  // R6: free entries keep their cells forced high and never become ready
  p_boost_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_BOOST) |-> (tags_q == BOOST_VAL && rdy_q == '0));

  // R2: allocation always takes the entry out of boost mode
  p_alloc_normal_r2: assert property (@(posedge clk) disable iff (rst)
    disp_hit_i |=> (mode_q == MODE_NORMAL));

  // R4: ready flags stick while the entry stays allocated
  p_sticky_ready_r4: assert property (@(posedge clk) disable iff (rst)
    (rdy_q[0] && !disp_hit_i && !free_hit_i) |=> rdy_q[0]);

  // R7: a free without a colliding dispatch clears the entry
  p_free_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (free_hit_i && !disp_hit_i) |=> (mode_q == MODE_BOOST && !req_q));
endmodule

// File: rtl/iq_wakeup_cam.sv
module iq_wakeup_cam
  import iqw_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int TAG_W       = 7,
  parameter int NUM_DISP    = 4,
  parameter int NUM_ISSUE   = 4,
  parameter int NUM_BCAST   = 4,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_DISP-1:0]             disp_vld_i,
  input  logic [NUM_DISP*IDX_W-1:0]       disp_idx_i,
  input  logic [NUM_DISP*2*TAG_W-1:0]     disp_tag_i,
  input  logic [NUM_DISP*2-1:0]           disp_rdy_i,
  input  logic [NUM_ISSUE-1:0]            free_vld_i,
  input  logic [NUM_ISSUE*IDX_W-1:0]      free_idx_i,
  input  logic [NUM_BCAST-1:0]            bc_vld_i,
  input  logic [NUM_BCAST*TAG_W-1:0]      bc_tag_i,
  output logic [NUM_ENTRIES-1:0]          entry_valid_o,
  output logic [NUM_ENTRIES*2-1:0]        src_ready_o,
  output logic [NUM_ENTRIES-1:0]          request_o
);
  localparam int SRC_TW = NUM_SRC * TAG_W;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    logic              d_hit, f_hit;
    logic [SRC_TW-1:0] d_tags;
    logic [NUM_SRC-1:0] d_rdy;

    always_comb begin
      d_hit  = 1'b0;
      d_tags = '0;
      d_rdy  = '0;
      for (int p = 0; p < NUM_DISP; p++) begin
        if (disp_vld_i[p] && disp_idx_i[p*IDX_W +: IDX_W] == IDX_W'(e)) begin
          d_hit  = 1'b1;
          d_tags = disp_tag_i[p*SRC_TW +: SRC_TW];
          d_rdy  = disp_rdy_i[p*NUM_SRC +: NUM_SRC];
        end
      end
    end

    always_comb begin
      f_hit = 1'b0;
      for (int p = 0; p < NUM_ISSUE; p++) begin
        if (free_vld_i[p] && free_idx_i[p*IDX_W +: IDX_W] == IDX_W'(e))
          f_hit = 1'b1;
      end
    end

    iqw_entry #(.TAG_W(TAG_W), .NUM_BCAST(NUM_BCAST)) u_entry (
      .clk         (clk),
      .rst         (rst),
      .disp_hit_i  (d_hit),
      .disp_tags_i (d_tags),
      .disp_rdy_i  (d_rdy),
      .free_hit_i  (f_hit),
      .bc_vld_i    (bc_vld_i),
      .bc_tag_i    (bc_tag_i),
      .valid_o     (entry_valid_o[e]),
      .rdy_o       (src_ready_o[e*NUM_SRC +: NUM_SRC]),
      .req_o       (request_o[e])
    );

    // R2: a dispatch may only target a free slot, or one freed in the same cycle
    p_alloc_free_slot_r2: assert property (@(posedge clk) disable iff (rst)
      d_hit |-> (!entry_valid_o[e] || f_hit));

    // R8: a request is only raised by a valid entry with both sources ready
    p_req_consistent_r8: assert property (@(posedge clk) disable iff (rst)
      request_o[e] |-> (entry_valid_o[e] && (&src_ready_o[e*NUM_SRC +: NUM_SRC])));
  end
endmodule

// File: tb/iq_wakeup_cam_tb_top.sv
module iq_wakeup_cam_tb_top;
  localparam int N  = 8;
  localparam int TW = 7;
  localparam int ND = 4;
  localparam int NI = 4;
  localparam int NB = 4;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst;
  logic [ND-1:0]      disp_vld;
  logic [ND*IW-1:0]   disp_idx;
  logic [ND*2*TW-1:0] disp_tag;
  logic [ND*2-1:0]    disp_rdy;
  logic [NI-1:0]      free_vld;
  logic [NI*IW-1:0]   free_idx;
  logic [NB-1:0]      bc_vld;
  logic [NB*TW-1:0]   bc_tag;
  logic [N-1:0]       ent_v;
  logic [N*2-1:0]     src_r;
  logic [N-1:0]       req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iq_wakeup_cam #(.NUM_ENTRIES(N), .TAG_W(TW), .NUM_DISP(ND),
                  .NUM_ISSUE(NI), .NUM_BCAST(NB)) dut_i (
    .clk(clk), .rst(rst),
    .disp_vld_i(disp_vld), .disp_idx_i(disp_idx),
    .disp_tag_i(disp_tag), .disp_rdy_i(disp_rdy),
    .free_vld_i(free_vld), .free_idx_i(free_idx),
    .bc_vld_i(bc_vld), .bc_tag_i(bc_tag),
    .entry_valid_o(ent_v), .src_ready_o(src_r), .request_o(req)
  );

  task automatic idle();
    disp_vld = '0; disp_idx = '0; disp_tag = '0; disp_rdy = '0;
    free_vld = '0; free_idx = '0; bc_vld = '0; bc_tag = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic disp(input int p, input int e, input int t0, input int t1,
                      input bit r0, input bit r1);
    disp_vld[p] = 1'b1;
    disp_idx[p*IW +: IW] = IW'(e);
    disp_tag[p*2*TW +: 2*TW] = {TW'(t1), TW'(t0)};
    disp_rdy[p*2 +: 2] = {r1, r0};
  endtask

  task automatic free(input int p, input int e);
    free_vld[p] = 1'b1;
    free_idx[p*IW +: IW] = IW'(e);
  endtask

  task automatic bcast(input int b, input int t, input bit v);
    bc_vld[b] = v;
    bc_tag[b*TW +: TW] = TW'(t);
  endtask

  task automatic chk(input string rq, input int e, input bit v, input bit r0,
                     input bit r1, input bit q);
    logic [3:0] act, exp;
    act = {ent_v[e], src_r[2*e], src_r[2*e+1], req[e]};
    exp = {v, r0, r1, q};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s entry %0d {valid,rdy0,rdy1,req} actual=%b expected=%b",
               rq, e, act, exp);
    end
  endtask

  task automatic t_reset();
    for (int e = 0; e < N; e++) chk("R1", e, 0, 0, 0, 0);
  endtask

  task automatic t_dispatch();
    disp(0, 1, 5, 9, 0, 0);
    disp(2, 3, 1, 2, 1, 1);
    step();
    chk("R2", 1, 1, 0, 0, 0);
    chk("R8", 3, 1, 1, 1, 1);
    chk("R2", 0, 0, 0, 0, 0);
  endtask

  task automatic t_wakeup();
    bcast(2, 5, 1);
    bcast(1, 8, 1);             // near miss of 9
    step();
    chk("R3", 1, 1, 1, 0, 0);
    bcast(3, 9, 0);             // matching tag, bus not valid
    step();
    chk("R10", 1, 1, 1, 0, 0);
    bcast(0, 9, 1);
    step();
    chk("R3", 1, 1, 1, 1, 1);
    step();
    step();
    chk("R4", 1, 1, 1, 1, 1);
  endtask

  task automatic t_free();
    free(3, 1);
    step();
    chk("R7", 1, 0, 0, 0, 0);
    chk("R7", 3, 1, 1, 1, 1);
  endtask

  task automatic t_boost();
    for (int b = 0; b < NB; b++) bcast(b, 127, 1);
    step();
    chk("R6", 0, 0, 0, 0, 0);
    chk("R6", 1, 0, 0, 0, 0);
    disp(1, 5, 127, 127, 0, 0);
    step();
    chk("R6", 5, 1, 0, 0, 0);
    bcast(3, 127, 1);
    step();
    chk("R6", 5, 1, 1, 1, 1);
  endtask

  task automatic t_same_cycle();
    disp(3, 6, 20, 21, 0, 0);
    bcast(1, 21, 1);
    step();
    chk("R5", 6, 1, 0, 1, 0);
  endtask

  task automatic t_collide();
    free(0, 3);
    disp(2, 3, 30, 31, 1, 0);
    free(1, 5);
    free(2, 6);
    step();
    chk("R9", 3, 1, 1, 0, 0);
    chk("R7", 5, 0, 0, 0, 0);
    chk("R7", 6, 0, 0, 0, 0);
    bcast(0, 31, 1);
    step();
    chk("R9", 3, 1, 1, 1, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_dispatch();
    t_wakeup();
    t_free();
    t_boost();
    t_same_cycle();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule